// File: doc/BRIEF.md
# Three-wire serial EEPROM device engine

This block is the device side of a byte-organised serial EEPROM with 512 words, reached over a three-wire link: a select line, a serial clock and a serial data input, plus one data output with an enable. The link inputs are brought into the system clock domain by a synchronizer. The serial clock's rising edges are then found by an edge detector, so the whole engine runs on a single clock. A frame opens with a start bit. Then come a two-bit opcode, a nine-bit address sent most significant bit first, and eight data bits for the two writing commands. The engine decodes seven commands: read, write, erase, erase-all, write-all, enable and disable.

Programming commands are gated by an enable latch. Each one launches a self-timed programming cycle when select drops after a complete frame. That cycle is a counter of `PROG_CYCLES` system clocks, and the array is updated when it completes. While the cycle runs, raising select makes the data output report busy (low), and then ready (high) once the cycle is done. Reads put out a dummy zero first and then stream data words, moving to the next address after each word.

The controller has eight named states. IDLE waits for a start bit and goes to OPCODE on it. OPCODE takes two bits and goes to ADDR. ADDR takes nine bits, then goes to READ for a read, to DATA for write or write-all, or to ARMED for any other command. DATA takes eight bits and goes to ARMED. READ streams until select drops and then returns to IDLE. ARMED waits for select to drop, then goes to PROG if a programming command is permitted, otherwise to IDLE. PROG holds until the timer finishes, then goes to READY if select is high or to IDLE if it is low. READY drives the ready level until select drops and then returns to IDLE. From OPCODE, ADDR, DATA and READ, a low select returns to IDLE.

Top module: `tw_eeprom_dev`

## Requirements
- R1: A frame starts only at the first serial clock rising edge at which select and data in are both high; rising edges seen with select high and data in low before that have no effect.
- R2: Opcode 11 is erase, 10 is read, 01 is write, and 00 selects by the two top address bits: 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R3: Commands without data are complete after 12 rising edges (start bit included), and write and write-all after 20; address and data are sent most significant bit first.
- R4: After the last address bit of a read, data out drives a 0, then each following rising edge puts out the next bit of the word, most significant first; reading continues at the next address and wraps from 511 to 0; data out is released when select drops.
- R5: The enable latch is cleared by reset and by the disable command; erase, write, erase-all and write-all do nothing while it is clear.
- R6: A complete programming frame launches its cycle when select goes low; the array changes only when the cycle completes, `PROG_CYCLES` system clocks later, whatever select does meanwhile.
- R7: A frame sent while a programming cycle runs is ignored.
- R8: During a programming cycle, a high select makes data out drive 0; after completion with select still high it drives 1; a low select releases it.
- R9: Erase sets the addressed word to FF, erase-all sets every word to FF, and write-all leaves every word equal to the data byte.
- R10: A frame cut short by select going low changes neither the array nor the enable latch.
- R11: After reset, every word reads FF and data out is released.
- R12: Once all bits of a command have arrived, further serial clocks and data bits before select drops are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low power-on reset |
| cs_i | input | 1 | Device select, active high |
| sclk_i | input | 1 | Serial clock from the master |
| din_i | input | 1 | Serial data input |
| dout_o | output | 1 | Serial data output value |
| dout_oe_o | output | 1 | Output enable for dout_o; low means high impedance |

## Verification
The assertions assume that select, serial clock and data in change slowly compared with the system clock. Each level is expected to hold for several system clocks, so the synchronizer never misses an edge. Data in is also expected to be stable when a rising serial edge is seen. Under these conditions, the checks that tie the start of a programming cycle to a low select and to a set enable latch hold exactly. The stimulus holds each serial clock phase for eight system clocks and changes data in only while the serial clock is low. It also keeps select low for at least eight system clocks between frames.

// File: rtl/tw_eeprom_pkg.sv
`timescale 1ns/1ps
package tw_eeprom_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_READ,
        CMD_WRITE,
        CMD_ERASE,
        CMD_ERAL,
        CMD_WRAL,
        CMD_EWEN,
        CMD_EWDS
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_ARMED,
        ST_PROG,
        ST_READY
    } ctl_state_e;

    // opcode plus the two top address bits select the command
    function automatic cmd_e decode_cmd(input logic [1:0] op, input logic [1:0] sel);
        cmd_e c;
        case (op)
            2'b11:   c = CMD_ERASE;
            2'b10:   c = CMD_READ;
            2'b01:   c = CMD_WRITE;
            default: begin
                case (sel)
                    2'b11:   c = CMD_EWEN;
                    2'b10:   c = CMD_ERAL;
                    2'b01:   c = CMD_WRAL;
                    default: c = CMD_EWDS;
                endcase
            end
        endcase
        return c;
    endfunction

    function automatic logic is_prog(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_ERAL) || (c == CMD_WRAL);
    endfunction

endpackage

// File: rtl/tw_eeprom_insync.sv
`timescale 1ns/1ps
module tw_eeprom_insync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stg_q <= '0;
                else         stg_q <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stg_q <= '0;
                else         stg_q <= {stg_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/tw_eeprom_ptimer.sv
`timescale 1ns/1ps
module tw_eeprom_ptimer #(
    parameter int CYCLES = 20000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start_i) begin
            cnt_q  <= CW'(CYCLES - 1);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0);

endmodule

// File: rtl/tw_eeprom_array.sv
`timescale 1ns/1ps
module tw_eeprom_array
    import tw_eeprom_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  cmd_e          op_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we_i) begin
            case (op_i)
                CMD_WRITE: mem_q[waddr_i] <= wdata_i;
                CMD_ERASE: mem_q[waddr_i] <= '1;
                CMD_ERAL:  for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
                // erase-then-fill collapses to the final fill pattern
                CMD_WRAL:  for (int i = 0; i < DEPTH; i++) mem_q[i] <= wdata_i;
                default:   ;
            endcase
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/tw_eeprom_ctrl.sv
`timescale 1ns/1ps
module tw_eeprom_ctrl
    import tw_eeprom_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cs_i,
    input  logic          sclk_i,
    input  logic          din_i,
    input  logic [DW-1:0] rdata_i,
    input  logic          prog_done_i,
    output logic          prog_start_o,
    output logic          mem_we_o,
    output cmd_e          mem_op_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          wen_o,
    output logic          dout_o,
    output logic          dout_oe_o
);

    localparam int MAXB = (AW > DW) ? AW : DW;
    localparam int CW   = $clog2(MAXB);
    localparam int RBW  = $clog2(DW);
    localparam logic [CW-1:0] OP_LAST = CW'(1);
    localparam logic [CW-1:0] AD_LAST = CW'(AW - 1);
    localparam logic [CW-1:0] DT_LAST = CW'(DW - 1);

    ctl_state_e     state_q, state_d;
    logic           sclk_q;
    logic           rise;
    logic [CW-1:0]  bit_cnt_q;
    logic [1:0]     op_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  data_q;
    cmd_e           cmd_q;
    logic           wen_q;
    logic           dout_q;
    logic [AW-1:0]  rd_addr_q;
    logic [RBW-1:0] rd_bit_q;
    logic [AW-1:0]  addr_full;
    cmd_e           cmd_dec;
    logic           launch;

    assign rise      = sclk_i & ~sclk_q;
    assign addr_full = {addr_q[AW-2:0], din_i};
    assign cmd_dec   = decode_cmd(op_q, addr_full[AW-1 -: 2]);
    assign launch    = (state_q == ST_ARMED) && !cs_i && is_prog(cmd_q) && wen_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_i && rise && din_i) state_d = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (!cs_i) state_d = ST_IDLE;
                else if (rise && bit_cnt_q == OP_LAST) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (!cs_i) state_d = ST_IDLE;
                else if (rise && bit_cnt_q == AD_LAST) begin
                    if (cmd_dec == CMD_READ) state_d = ST_READ;
                    else if (cmd_dec == CMD_WRITE || cmd_dec == CMD_WRAL) state_d = ST_DATA;
                    else state_d = ST_ARMED;
                end
            end
            ST_DATA: begin
                if (!cs_i) state_d = ST_IDLE;
                else if (rise && bit_cnt_q == DT_LAST) state_d = ST_ARMED;
            end
            ST_READ: begin
                if (!cs_i) state_d = ST_IDLE;
            end
            ST_ARMED: begin
                if (!cs_i) state_d = launch ? ST_PROG : ST_IDLE;
            end
            ST_PROG: begin
                if (prog_done_i) state_d = cs_i ? ST_READY : ST_IDLE;
            end
            ST_READY: begin
                if (!cs_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // shift registers, read pointer and enable latch
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sclk_q    <= 1'b0;
            bit_cnt_q <= '0;
            op_q      <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            cmd_q     <= CMD_NONE;
            wen_q     <= 1'b0;
            dout_q    <= 1'b0;
            rd_addr_q <= '0;
            rd_bit_q  <= RBW'(DW - 1);
        end else begin
            sclk_q <= sclk_i;
            case (state_q)
                ST_IDLE: begin
                    if (cs_i && rise && din_i) bit_cnt_q <= '0;
                end
                ST_OPCODE: begin
                    if (cs_i && rise) begin
                        op_q      <= {op_q[0], din_i};
                        bit_cnt_q <= (bit_cnt_q == OP_LAST) ? '0 : bit_cnt_q + 1'b1;
                    end
                end
                ST_ADDR: begin
                    if (cs_i && rise) begin
                        addr_q    <= addr_full;
                        bit_cnt_q <= (bit_cnt_q == AD_LAST) ? '0 : bit_cnt_q + 1'b1;
                        if (bit_cnt_q == AD_LAST) begin
                            cmd_q     <= cmd_dec;
                            rd_addr_q <= addr_full;
                            rd_bit_q  <= RBW'(DW - 1);
                            dout_q    <= 1'b0;
                        end
                    end
                end
                ST_DATA: begin
                    if (cs_i && rise) begin
                        data_q    <= {data_q[DW-2:0], din_i};
                        bit_cnt_q <= (bit_cnt_q == DT_LAST) ? '0 : bit_cnt_q + 1'b1;
                    end
                end
                ST_READ: begin
                    if (cs_i && rise) begin
                        dout_q <= rdata_i[rd_bit_q];
                        if (rd_bit_q == '0) begin
                            rd_addr_q <= rd_addr_q + 1'b1;
                            rd_bit_q  <= RBW'(DW - 1);
                        end else begin
                            rd_bit_q <= rd_bit_q - 1'b1;
                        end
                    end
                end
                ST_ARMED: begin
                    if (!cs_i) begin
                        if (cmd_q == CMD_EWEN)      wen_q <= 1'b1;
                        else if (cmd_q == CMD_EWDS) wen_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        prog_start_o = launch;
        mem_we_o     = (state_q == ST_PROG) && prog_done_i;
        mem_op_o     = cmd_q;
        mem_addr_o   = addr_q;
        mem_wdata_o  = data_q;
        rd_addr_o    = rd_addr_q;
        wen_o        = wen_q;
        dout_o       = 1'b0;
        dout_oe_o    = 1'b0;
        unique case (state_q)
            ST_READ: begin
                dout_o    = dout_q;
                dout_oe_o = cs_i;
            end
            ST_PROG: begin
                dout_o    = 1'b0;
                dout_oe_o = cs_i;
            end
            ST_READY: begin
                dout_o    = 1'b1;
                dout_oe_o = cs_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tw_eeprom_dev.sv
`timescale 1ns/1ps
module tw_eeprom_dev
    import tw_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 20000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic din_i,
    output logic dout_o,
    output logic dout_oe_o
);

    logic [2:0]        sync_lvl;
    logic              cs_s, sclk_s, din_s;
    logic              prog_start, prog_busy, prog_done;
    logic              mem_we;
    cmd_e              mem_op;
    logic [ADDR_W-1:0] mem_addr, rd_addr;
    logic [DATA_W-1:0] mem_wdata, rd_data;
    logic              wen;

    tw_eeprom_insync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({cs_i, sclk_i, din_i}),
        .sync_o  (sync_lvl)
    );

    assign {cs_s, sclk_s, din_s} = sync_lvl;

    tw_eeprom_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cs_i         (cs_s),
        .sclk_i       (sclk_s),
        .din_i        (din_s),
        .rdata_i      (rd_data),
        .prog_done_i  (prog_done),
        .prog_start_o (prog_start),
        .mem_we_o     (mem_we),
        .mem_op_o     (mem_op),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .rd_addr_o    (rd_addr),
        .wen_o        (wen),
        .dout_o       (dout_o),
        .dout_oe_o    (dout_oe_o)
    );

    tw_eeprom_ptimer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (prog_start),
        .busy_o  (prog_busy),
        .done_o  (prog_done)
    );

    tw_eeprom_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (mem_we),
        .op_i    (mem_op),
        .waddr_i (mem_addr),
        .wdata_i (mem_wdata),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

endmodule

// File: rtl/tw_eeprom_dev_chk.sv
`timescale 1ns/1ps
module tw_eeprom_dev_chk #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          cs_s,
    input logic          prog_busy,
    input logic          wen,
    input logic          dout_o,
    input logic          dout_oe_o,
    input logic          mem_we,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data
);

    AST_PROG_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(prog_busy) |-> wen) else $error("programming without enable"); // R5

    AST_LAUNCH_ON_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(prog_busy) |-> !$past(cs_s)) else $error("launch with select high"); // R6

    AST_ARRAY_WRITE_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we |-> prog_busy) else $error("array write outside cycle"); // R6

    AST_BUSY_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prog_busy && dout_oe_o) |-> !dout_o) else $error("busy not low"); // R8

    AST_ARRAY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($stable(rd_addr) && !$past(mem_we)) |-> $stable(rd_data)) else $error("array changed"); // R10

endmodule

bind tw_eeprom_dev tw_eeprom_dev_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_s      (cs_s),
    .prog_busy (prog_busy),
    .wen       (wen),
    .dout_o    (dout_o),
    .dout_oe_o (dout_oe_o),
    .mem_we    (mem_we),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/tw_eeprom_dev_tb_top.sv
`timescale 1ns/1ps
module tw_eeprom_dev_tb_top;

    localparam int AW    = 9;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int PROG  = 600;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sclk = 1'b0;
    logic din = 1'b0;
    logic dout;
    logic dout_oe;

    always #2.5 clk = ~clk;

    tw_eeprom_dev #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .cs_i      (cs),
        .sclk_i    (sclk),
        .din_i     (din),
        .dout_o    (dout),
        .dout_oe_o (dout_oe)
    );

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        logic [DW-1:0] val;
        string         tag;
    } exp_t;

    exp_t          exp_q[$];
    logic [DW-1:0] act_q[$];
    logic [DW-1:0] model [DEPTH];
    bit            model_wen;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic shift_out(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            din = v[i];
            pulse();
        end
        din = 1'b0;
    endtask

    task automatic open_frame(input int idle_clks);
        cs  = 1'b1;
        din = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < idle_clks; i++) pulse();
    endtask

    task automatic close_frame();
        cs  = 1'b0;
        din = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic header(input logic [1:0] op, input logic [AW-1:0] a);
        shift_out(16'd1, 1);
        shift_out({14'd0, op}, 2);
        shift_out({7'd0, a}, AW);
    endtask

    task automatic settle();
        wait_clk(PROG + 40);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int idle_clks);
        open_frame(idle_clks);
        header(2'b01, a);
        shift_out({8'd0, d}, DW);
        close_frame();
        if (model_wen) model[a] = d;
        settle();
    endtask

    task automatic do_erase(input logic [AW-1:0] a);
        open_frame(0);
        header(2'b11, a);
        close_frame();
        if (model_wen) model[a] = '1;
        settle();
    endtask

    task automatic do_eral();
        open_frame(0);
        header(2'b00, 9'h100);
        close_frame();
        if (model_wen) for (int i = 0; i < DEPTH; i++) model[i] = '1;
        settle();
    endtask

    task automatic do_wral(input logic [DW-1:0] d);
        open_frame(0);
        header(2'b00, 9'h080);
        shift_out({8'd0, d}, DW);
        close_frame();
        if (model_wen) for (int i = 0; i < DEPTH; i++) model[i] = d;
        settle();
    endtask

    task automatic do_ewen();
        open_frame(0);
        header(2'b00, 9'h180);
        close_frame();
        model_wen = 1'b1;
    endtask

    task automatic do_ewds();
        open_frame(0);
        header(2'b00, 9'h000);
        close_frame();
        model_wen = 1'b0;
    endtask

    // driver: expected words go to the scoreboard, captured words to the monitor
    task automatic do_read(input logic [AW-1:0] a, input int n, input string tag);
        logic [DW-1:0] b;
        open_frame(0);
        header(2'b10, a);
        chk(dout_oe === 1'b1 && dout === 1'b0, {tag, " R4 dummy zero"}, {dout_oe, dout}, 2'b10);
        for (int w = 0; w < n; w++) begin
            exp_q.push_back('{model[(int'(a) + w) % DEPTH], tag});
            b = '0;
            for (int i = 0; i < DW; i++) begin
                pulse();
                b = {b[DW-2:0], dout};
            end
            act_q.push_back(b);
        end
        close_frame();
        chk(dout_oe === 1'b0, {tag, " R4 released on deselect"}, dout_oe, 0);
    endtask

    task automatic do_write_status(input logic [AW-1:0] a, input logic [DW-1:0] d);
        open_frame(0);
        header(2'b01, a);
        shift_out({8'd0, d}, DW);
        close_frame();
        cs = 1'b1;
        wait_clk(HALF);
        chk(dout_oe === 1'b1 && dout === 1'b0, "R8 R6 busy while programming", {dout_oe, dout}, 2'b10);
        wait_clk(PROG + 20);
        chk(dout_oe === 1'b1 && dout === 1'b1, "R8 ready after cycle", {dout_oe, dout}, 2'b11);
        cs = 1'b0;
        wait_clk(HALF);
        chk(dout_oe === 1'b0, "R8 released on deselect", dout_oe, 0);
        if (model_wen) model[a] = d;
        wait_clk(40);
    endtask

    // monitor: compares each captured word with the head of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() > 0) begin
                logic [DW-1:0] got;
                exp_t          e;
                got = act_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk(1'b0, "scoreboard underflow R4", got, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(got === e.val, e.tag, got, e.val);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '1;
        model_wen = 1'b0;
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(10);

        chk(dout_oe === 1'b0, "R11 released after reset", dout_oe, 0);
        do_read(9'd0, 2, "R11 erased after reset");

        // R5: locked after reset
        do_write(9'd3, 8'h5A, 0);
        do_read(9'd3, 1, "R5 write ignored while locked");

        // R6 R8 status, then R3 R4 sequential read
        do_ewen();
        do_write_status(9'd3, 8'hA5);
        do_write(9'd4, 8'hC3, 0);
        do_read(9'd3, 3, "R3 R4 sequential read");

        // R1: idle clocks before the start bit
        do_write(9'd511, 8'h3C, 5);
        do_read(9'd511, 2, "R1 R4 wrap from top address");

        // R10: aborted frames
        do_write(9'd30, 8'h44, 0);
        open_frame(0);
        header(2'b01, 9'd30);
        shift_out(16'h0, 4);
        close_frame();
        settle();
        open_frame(0);
        shift_out(16'd1, 1);
        shift_out(16'd0, 2);
        shift_out(16'd0, 5);
        close_frame();
        do_write(9'd31, 8'h77, 0);
        do_read(9'd30, 2, "R10 aborted frames ignored");

        // R12: trailing clocks after a complete write
        open_frame(0);
        header(2'b01, 9'd10);
        shift_out({8'd0, 8'h11}, DW);
        din = 1'b1;
        for (int i = 0; i < 5; i++) pulse();
        close_frame();
        if (model_wen) model[10] = 8'h11;
        settle();
        do_read(9'd10, 1, "R12 trailing bits ignored");

        // R7: frame during a programming cycle
        open_frame(0);
        header(2'b01, 9'd20);
        shift_out({8'd0, 8'h22}, DW);
        close_frame();
        open_frame(0);
        header(2'b01, 9'd21);
        shift_out({8'd0, 8'h33}, DW);
        close_frame();
        model[20] = 8'h22;
        settle();
        do_read(9'd20, 2, "R7 frame while busy ignored");

        // R2 R9 erase
        do_erase(9'd3);
        do_read(9'd3, 2, "R2 R9 erase word");

        // R5 disable
        do_ewds();
        do_erase(9'd20);
        do_read(9'd20, 1, "R5 erase ignored after disable");

        // R2 R9 write-all and erase-all
        do_ewen();
        do_wral(8'h6B);
        do_read(9'd0, 2, "R2 R9 write-all");
        do_read(9'd510, 3, "R2 R9 write-all wrap");
        do_eral();
        do_read(9'd100, 2, "R2 R9 erase-all");

        wait_clk(20);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule